// File: doc/BRIEF.md
# Banked Scratchpad Conflict Resolver

This block owns a word-addressed on-chip scratchpad split into independent banks, each able to do one read or one write per cycle. A request carries, for every lane, an active bit, a word address and write data, plus one read/write flag shared by the whole request. Lanes whose addresses land in distinct banks are served together. Two active lanes that need different words of one bank cannot share a cycle, so the resolver replays the request over as many consecutive passes as the worst bank needs. Lanes asking for the very same word are served by a single bank access and cost nothing extra.

The request side is a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high, and every request field is sampled at that edge only. There is no back-pressure on the response: `rsp_done` pulses for one cycle, and `rsp_rdata` keeps its value from that pulse until the next request is accepted. Defaults are 32 lanes, 32 banks, 64 rows per bank (parameter `ROWS`; 512 gives the full 64 KB array) and 32-bit words. `BANKS` and `ROWS` must be powers of two, and `BANKS` at least 2.

Top module: `bank_conflict_sequencer`

## Requirements
- R1: While reset is held and after its release, `req_ready` is 1, `rsp_done` is 0 and `rsp_rdata` is all zero.
- R2: A request is accepted only on an edge with `req_valid` and `req_ready` both high. `req_ready` is 0 in every cycle from that edge until the `rsp_done` cycle, and it is 1 again in the `rsp_done` cycle.
- R3: Lane `l`'s address is `req_addr[l*AW +: AW]`, with AW = log2(BANKS)+log2(ROWS). Its low log2(BANKS) bits select the bank and the bits above them select the row. Lanes that differ only in the row bits fall in one bank; lanes that differ in the low bits never conflict.
- R4: The number of passes P is the largest count, over all banks, of distinct words addressed by active lanes in that bank, with a minimum of 1 (an empty mask still takes one pass). With acceptance at edge k, `rsp_done` is high in the cycle that follows edge k+P.
- R5: Any number of active lanes that address the same word add no pass beyond the one that word needs, and each of them returns that word.
- R6: For a read (`req_write`=0), lane `l` of `rsp_rdata` (bits `[l*DW +: DW]`) holds the stored word at its address when its `req_mask` bit is 1, and 0 when its mask bit is 0. For a write, all of `rsp_rdata` is 0. The value is held until the next accepted request.
- R7: For a write (`req_write`=1), each active lane stores `req_wdata[l*DW +: DW]` at its address. When several active lanes write one word, the highest-numbered lane's data is stored.
- R8: A lane whose mask bit is 0 changes no stored word, whatever its address and data.
- R9: `rsp_done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request taken when valid is also high |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_mask | input | LANES | Active bit per lane |
| req_addr | input | LANES*AW | Word address per lane, lane l at `[l*AW +: AW]` |
| req_wdata | input | LANES*DW | Write data per lane, lane l at `[l*DW +: DW]` |
| rsp_done | output | 1 | One-cycle pulse after the final pass |
| rsp_rdata | output | LANES*DW | Read data per lane, held until the next request |

## Verification
A wrong pending-lane set shows up as a pass count off by one or more, so `rsp_done` arrives early or late on the very request that went wrong. A wrong choice of word in a bank, or a lost write winner, shows up as a wrong lane of `rsp_rdata` on the next read of that word, which can be many requests later. The bench therefore keeps a model of every word and reads back the whole small array over and over. Handshake faults show as `req_ready` rising without `rsp_done`, or `rsp_done` lasting two cycles.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } scr_state_e;
endpackage

// File: rtl/bank_picker.sv
// Per-bank selector: finds the lowest-numbered pending lane aimed at this
// bank, then marks every pending lane that wants that same word.
module bank_picker #(
  parameter int LANES   = 32,
  parameter int BW      = 5,
  parameter int AW      = 11,
  parameter int DW      = 32,
  parameter int BANK_ID = 0
) (
  input  logic [LANES-1:0]    pend,
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES*DW-1:0] wdata,
  output logic                hit,
  output logic [AW-BW-1:0]    row,
  output logic [LANES-1:0]    serve,
  output logic [DW-1:0]       wsel
);
  localparam logic [BW-1:0] MY_BANK = BW'(BANK_ID);

  logic [LANES-1:0] cand;
  logic [AW-1:0]    pick;

  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int l = 0; l < LANES; l++) begin
      cand[l] = pend[l] && (addr[l*AW +: BW] == MY_BANK);
    end
    for (int l = 0; l < LANES; l++) begin
      if (cand[l] && !hit) begin
        hit  = 1'b1;
        pick = addr[l*AW +: AW];
      end
    end
    wsel = '0;
    for (int l = 0; l < LANES; l++) begin
      serve[l] = cand[l] && (addr[l*AW +: AW] == pick);
      if (serve[l]) wsel = wdata[l*DW +: DW];
    end
    row = pick[AW-1:BW];
  end
endmodule

// File: rtl/bank_store.sv
// One bank: combinational read of the addressed row, write on the clock.
module bank_store #(
  parameter int ROWS = 64,
  parameter int RW   = 6,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wdata;
  end

  assign rdata = mem[row];
endmodule

// File: rtl/bank_conflict_sequencer.sv
module bank_conflict_sequencer #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int ROWS  = 64,
  parameter int DW    = 32,
  localparam int BW   = $clog2(BANKS),
  localparam int RW   = $clog2(ROWS),
  localparam int AW   = BW + RW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [LANES-1:0]    req_mask,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                rsp_done,
  output logic [LANES*DW-1:0] rsp_rdata
);
  import scr_pkg::*;

  scr_state_e          state_q;
  logic [LANES-1:0]    pend_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*DW-1:0] wdata_q;
  logic                write_q;
  logic [LANES*DW-1:0] rdata_q;
  logic                done_q;

  logic                busy;
  logic [LANES-1:0]    serve_b [BANKS];
  logic [LANES-1:0]    serve_all;
  logic [LANES-1:0]    pend_nxt;
  logic [BANKS-1:0]    bank_hit;
  logic [RW-1:0]       bank_row [BANKS];
  logic [DW-1:0]       bank_wd  [BANKS];
  logic [DW-1:0]       bank_rd  [BANKS];

  assign busy = (state_q == ST_BUSY);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    bank_picker #(
      .LANES(LANES), .BW(BW), .AW(AW), .DW(DW), .BANK_ID(b)
    ) u_pick (
      .pend (pend_q),
      .addr (addr_q),
      .wdata(wdata_q),
      .hit  (bank_hit[b]),
      .row  (bank_row[b]),
      .serve(serve_b[b]),
      .wsel (bank_wd[b])
    );

    bank_store #(
      .ROWS(ROWS), .RW(RW), .DW(DW)
    ) u_store (
      .clk  (clk),
      .we   (busy && write_q && bank_hit[b]),
      .row  (bank_row[b]),
      .wdata(bank_wd[b]),
      .rdata(bank_rd[b])
    );
  end

  // Every lane maps to exactly one bank, so the per-bank masks are disjoint.
  always_comb begin
    serve_all = '0;
    for (int b = 0; b < BANKS; b++) serve_all = serve_all | serve_b[b];
    pend_nxt = pend_q & ~serve_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            pend_q  <= req_mask;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
            rdata_q <= '0;
            state_q <= ST_BUSY;
          end
        end
        default: begin
          pend_q <= pend_nxt;
          for (int l = 0; l < LANES; l++) begin
            if (serve_all[l] && !write_q)
              rdata_q[l*DW +: DW] <= bank_rd[addr_q[l*AW +: BW]];
          end
          if (pend_nxt == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter int LANES = 32,
  parameter int DW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                rsp_done,
  input logic [LANES*DW-1:0] rsp_rdata,
  input logic                busy,
  input logic [LANES-1:0]    pend_q,
  input logic [LANES-1:0]    serve_all
);
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready); // R2
  AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_READY_RETURNS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(req_ready) && req_ready) |-> rsp_done); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R9
  AST_PASS_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (pend_q != '0)) |-> (serve_all != '0)); // R4
  AST_SERVE_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((serve_all & ~pend_q) == '0)); // R4
  AST_RDATA_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> $stable(rsp_rdata)); // R6
endmodule

bind bank_conflict_sequencer scr_checker #(
  .LANES(LANES), .DW(DW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_done (rsp_done),
  .rsp_rdata(rsp_rdata),
  .busy     (busy),
  .pend_q   (pend_q),
  .serve_all(serve_all)
);

// File: tb/sim_bank_conflict_sequencer.sv
module sim_bank_conflict_sequencer;
  localparam int L  = 8;
  localparam int B  = 4;
  localparam int RN = 4;
  localparam int D  = 16;
  localparam int BT = 2;
  localparam int AT = 4;
  localparam int NW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic [L-1:0]    req_mask = '0;
  logic [L*AT-1:0] req_addr = '0;
  logic [L*D-1:0]  req_wdata = '0;
  logic            rsp_done;
  logic [L*D-1:0]  rsp_rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [D-1:0]  model [NW];
  logic [31:0]   seed = 32'h1234_5678;

  always #4 clk = ~clk;

  bank_conflict_sequencer #(.LANES(L), .BANKS(B), .ROWS(RN), .DW(D)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mask(req_mask), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, cycle %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what,
                     input logic [L*D-1:0] act, input logic [L*D-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic int exp_passes(input logic [L-1:0] m, input logic [L*AT-1:0] a);
    int worst = 1;
    for (int b = 0; b < B; b++) begin
      int cnt = 0;
      for (int l = 0; l < L; l++) begin
        if (m[l] && (a[l*AT +: BT] == BT'(b))) begin
          bit seen = 1'b0;
          for (int k = 0; k < l; k++)
            if (m[k] && (a[k*AT +: AT] == a[l*AT +: AT])) seen = 1'b1;
          if (!seen) cnt++;
        end
      end
      if (cnt > worst) worst = cnt;
    end
    return worst;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic run_req(input logic w, input logic [L-1:0] m,
                         input logic [L*AT-1:0] a, input logic [L*D-1:0] wd,
                         input string tag);
    int ep = exp_passes(m, a);
    logic [L*D-1:0] erd = '0;
    logic [L*D-1:0] held;
    int  cnt = 0;
    bit  busy_ok = 1'b1;
    if (!w)
      for (int l = 0; l < L; l++)
        if (m[l]) erd[l*D +: D] = model[a[l*AT +: AT]];
    @(negedge clk);
    req_write = w; req_mask = m; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      if (!rsp_done) begin
        if (req_ready) busy_ok = 1'b0;
        @(posedge clk);
        cnt++;
      end
    end while (!rsp_done && cnt < 100);
    chk(cnt == ep, {"R4 pass count ", tag}, (L*D)'(cnt), (L*D)'(ep));
    chk(busy_ok, {"R2 ready low while busy ", tag}, (L*D)'(busy_ok), (L*D)'(1));
    chk(req_ready == 1'b1, {"R2 ready in done cycle ", tag}, (L*D)'(req_ready), (L*D)'(1));
    chk(rsp_rdata === erd, {"R6 read data ", tag}, rsp_rdata, erd);
    held = rsp_rdata;
    @(negedge clk);
    chk(rsp_done == 1'b0, {"R9 done single cycle ", tag}, (L*D)'(rsp_done), '0);
    @(negedge clk);
    chk(rsp_rdata === held, {"R6 data held ", tag}, rsp_rdata, held);
    if (w)
      for (int l = 0; l < L; l++)
        if (m[l]) model[a[l*AT +: AT]] = wd[l*D +: D];
  endtask

  initial begin
    logic [L*AT-1:0] a;
    logic [L*D-1:0]  wd;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && rsp_done == 1'b0, "R1 ready/done in reset",
        (L*D)'({req_ready, rsp_done}), (L*D)'(2'b10));
    chk(rsp_rdata == '0, "R1 rdata in reset", rsp_rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_done == 1'b0 && rsp_rdata == '0,
        "R1 state after reset", (L*D)'({req_ready, rsp_done}), (L*D)'(2'b10));

    // Fill every word: two distinct words per bank per request (R7)
    for (int h = 0; h < 2; h++) begin
      for (int l = 0; l < L; l++) begin
        a[l*AT +: AT] = AT'(l + 8*h);
        wd[l*D +: D]  = D'(16'hA000 + l + 8*h);
      end
      run_req(1'b1, 8'hFF, a, wd, "R7 fill");
    end
    // Read all words back
    for (int h = 0; h < 2; h++) begin
      for (int l = 0; l < L; l++) a[l*AT +: AT] = AT'(l + 8*h);
      run_req(1'b0, 8'hFF, a, '0, "R7 readback");
    end
    // Broadcast: all lanes one word -> one pass (R5)
    for (int l = 0; l < L; l++) a[l*AT +: AT] = 4'd5;
    run_req(1'b0, 8'hFF, a, '0, "R5 broadcast");
    // Two words per bank, each requested by four lanes -> two passes (R5)
    for (int l = 0; l < L; l++) a[l*AT +: AT] = (l < 4) ? 4'd2 : 4'd14;
    run_req(1'b0, 8'hFF, a, '0, "R5 shared pairs");
    // Same low bits, different rows: four passes (R3)
    for (int l = 0; l < L; l++) a[l*AT +: AT] = AT'({l[1:0], 2'b01});
    run_req(1'b0, 8'hFF, a, '0, "R3 same bank rows");
    // Same row, different low bits: one pass (R3)
    for (int l = 0; l < L; l++) a[l*AT +: AT] = AT'({2'b11, l[1:0]});
    run_req(1'b0, 8'h0F, a, '0, "R3 distinct banks");
    // Empty mask: one pass, zero data (R4, R6)
    run_req(1'b0, 8'h00, a, '0, "R4 empty mask");
    // Lanes 2 and 5 write word 7: lane 5 wins (R7)
    for (int l = 0; l < L; l++) begin
      a[l*AT +: AT] = 4'd7;
      wd[l*D +: D]  = D'(16'h7000 + l);
    end
    run_req(1'b1, 8'b0010_0100, a, wd, "R7 same word writers");
    run_req(1'b0, 8'h01, a, '0, "R7 winner readback");
    chk(rsp_rdata[0 +: D] == 16'h7005, "R7 highest lane stored",
        (L*D)'(rsp_rdata[0 +: D]), (L*D)'(16'h7005));
    // Masked lanes write nothing (R8)
    for (int l = 0; l < L; l++) begin
      a[l*AT +: AT] = (l == 0) ? 4'd3 : 4'd4;
      wd[l*D +: D]  = D'(16'hBEE0 + l);
    end
    run_req(1'b1, 8'h01, a, wd, "R8 masked write");
    for (int l = 0; l < L; l++) a[l*AT +: AT] = 4'd4;
    run_req(1'b0, 8'hFF, a, '0, "R8 untouched word");
    chk(rsp_rdata[0 +: D] == 16'hA004, "R8 inactive lanes kept word 4",
        (L*D)'(rsp_rdata[0 +: D]), (L*D)'(16'hA004));
    // Pseudo-random sweep over the 16-word array
    for (int n = 0; n < 400; n++) begin
      logic w;
      logic [L-1:0] m;
      seed = nxt(seed); w = (seed[31:30] == 2'b00);
      seed = nxt(seed); m = seed[23:16];
      for (int l = 0; l < L; l++) begin
        seed = nxt(seed);
        a[l*AT +: AT] = seed[27:24];
        wd[l*D +: D]  = seed[15:0];
      end
      run_req(w, m, a, wd, w ? "R7 sweep write" : "R4 sweep read");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule